// File: doc/BRIEF.md
# Double-Buffered Serial Vector Playback Engine

This block replays stored bit vectors as continuous serial waveforms on a set of parallel channels. Every channel reads one byte per eight run-clock periods from its own vector memory and sends the bits out one per run-clock period, least significant bit first. Each channel has two parallel-load shift registers. One shifts out the current word while the other loads the next word, and the two swap roles every eight steps, so the stream has no gaps.

A single phase counter and a single vector address counter serve all channels, so every channel is at the same point of its vector at all times. The address counter passes through the whole memory and wraps back to zero, and the pattern then repeats. A hold bit freezes all playback state and releases the memory address bus. Clearing the hold bit resumes playback from the exact point where it stopped. An output-enable latch tells the pads whether to drive the serial bits or tri-state them. A timing-register write strobe clears this latch and an output-enable write strobe sets it.

The system clock is `clk`. The run clock is supplied as the one-cycle enable `socEn`. One step happens on each rising edge of `clk` where `socEn` is 1 and `clkHold` is 0.

Top module: `vecPlayback`

## Requirements
- R1: After reset the following hold: every `chanBit` is 0, `memAddr` is 0, `outDrive` is 0, and both shift registers of every channel are cleared. As a result, the first eight steps produce 0 on every channel.
- R2: Each step moves one bit to `chanBit`. The bits of a word come out least significant bit first, so the word 67h gives the sequence 1,1,1,0,0,1,1,0.
- R3: Number the steps from 0. The output after step k is bit (k mod 8) of word (k/8 − 1). Word 0 therefore starts appearing at step 8.
- R4: `memAddr` goes up by one after every eighth step, and only then. It is `ADDR_W` bits wide and wraps from 2047 to 0 with no extra step.
- R5: While `clkHold` is 1, the following hold: `memAddrValid` is 0, and the outputs, the address and the internal phase do not change. After `clkHold` returns to 0, the sequence continues with no bit lost or repeated.
- R6: A clock edge with `socEn` low changes neither `chanBit` nor `memAddr`.
- R7: A pulse on `oeStrobe` sets `outDrive` to 1 from the next cycle onward. A pulse on `timStrobe` clears it to 0. With neither strobe active, `outDrive` keeps its value whatever playback is doing.
- R8: Channel c takes its data from `memRdata[c*8 +: 8]`. All channels use the same address and phase, so they stay bit-aligned while carrying independent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| socEn | input | 1 | Run-clock enable, one pulse per output period |
| clkHold | input | 1 | 1 = playback frozen and address bus released |
| timStrobe | input | 1 | Timing-register write strobe; clears the output enable |
| oeStrobe | input | 1 | Output-enable write strobe; sets the output enable |
| memRdata | input | NCH*8 | Combinational read data, one byte per channel |
| memAddr | output | ADDR_W | Shared vector read address |
| memAddrValid | output | 1 | 1 while the counter drives the address bus |
| chanBit | output | NCH | Serial output bit of each channel |
| outDrive | output | 1 | 1 = drive the channel pads, 0 = tri-state |

## Verification
The hardest condition to reach from the ports is the address wrap. It happens only after 16384 consecutive steps, and at that point both the continuity of the stream and the buffer swap must stay correct. The stimulus reaches it by holding `socEn` high for more than a full pass of the memory. Before that, it runs sections with sparse `socEn` and with `clkHold` set, so that the wrap takes place after the phase has already been frozen and resumed. Every memory word has a distinct value per channel, so a misaligned or skipped word shows up at once in the per-step comparison.

// File: rtl/vp_pkg.sv
package vp_pkg;
  typedef struct packed {
    logic step;
    logic load;
    logic sel;
  } vpStrobe_t;
endpackage

// File: rtl/vpCtl.sv
module vpCtl #(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 socEn,
  input  logic                 clkHold,
  input  logic                 timStrobe,
  input  logic                 oeStrobe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memAddrValid,
  output logic                 outDrive,
  output vp_pkg::vpStrobe_t    strb
);
  localparam int PH_W = $clog2(WORD_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  logic [PH_W-1:0]   phase;
  logic [ADDR_W-1:0] addrCnt;
  logic              bufSel;
  logic              oeLatch;
  logic              stepNow;
  logic              loadNow;

  assign stepNow = socEn && !clkHold;
  assign loadNow = stepNow && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      addrCnt <= '0;
      bufSel  <= 1'b0;
    end else if (stepNow) begin
      phase <= phase + 1'b1;
      if (loadNow) begin
        addrCnt <= addrCnt + 1'b1;
        bufSel  <= ~bufSel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          oeLatch <= 1'b0;
    else if (timStrobe) oeLatch <= 1'b0;
    else if (oeStrobe)  oeLatch <= 1'b1;
  end

  assign memAddr      = addrCnt;
  assign memAddrValid = !clkHold;
  assign outDrive     = oeLatch;
  assign strb.step    = stepNow;
  assign strb.load    = loadNow;
  assign strb.sel     = bufSel;

  AST_ADDR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> $past(strb.load)); // R4
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memAddr) == ADDR_MAX && !$stable(memAddr)) |-> memAddr == '0); // R4
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (clkHold || !socEn) |=> $stable(memAddr)); // R5
  AST_OE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (oeStrobe && !timStrobe) |=> outDrive); // R7
  AST_OE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    timStrobe |=> !outDrive); // R7
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!oeStrobe && !timStrobe) |=> $stable(outDrive)); // R7
endmodule

// File: rtl/vpDatapath.sv
module vpDatapath #(
  parameter int NCH    = 8,
  parameter int WORD_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vp_pkg::vpStrobe_t      strb,
  input  logic [NCH*WORD_W-1:0]  memRdata,
  output logic [NCH-1:0]         chanBit
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [WORD_W-1:0] shA;
    logic [WORD_W-1:0] shB;
    logic              outQ;
    logic [WORD_W-1:0] word;

    assign word = memRdata[c*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shA  <= '0;
        shB  <= '0;
        outQ <= 1'b0;
      end else if (strb.step) begin
        if (strb.sel) begin
          outQ <= shB[0];
          shB  <= shB >> 1;
          if (strb.load) shA <= word;
        end else begin
          outQ <= shA[0];
          shA  <= shA >> 1;
          if (strb.load) shB <= word;
        end
      end
    end

    assign chanBit[c] = outQ;
  end

  AST_BITS_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanBit) |-> $past(strb.step)); // R6
  AST_LOAD_IMPLIES_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> strb.step); // R5
endmodule

// File: rtl/vecPlayback.sv
module vecPlayback #(
  parameter int NCH    = 8,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  socEn,
  input  logic                  clkHold,
  input  logic                  timStrobe,
  input  logic                  oeStrobe,
  input  logic [NCH*WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memAddrValid,
  output logic [NCH-1:0]        chanBit,
  output logic                  outDrive
);
  vp_pkg::vpStrobe_t strb;

  vpCtl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .socEn(socEn), .clkHold(clkHold),
    .timStrobe(timStrobe), .oeStrobe(oeStrobe),
    .memAddr(memAddr), .memAddrValid(memAddrValid),
    .outDrive(outDrive), .strb(strb)
  );

  vpDatapath #(.NCH(NCH), .WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .memRdata(memRdata), .chanBit(chanBit)
  );

  AST_HOLD_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    clkHold |=> $stable(chanBit)); // R5
endmodule

// File: tb/vecPlayback_test.sv
module vecPlayback_test;
  localparam int NCH = 8;
  localparam int DEPTH = 2048;

  logic clk = 0;
  logic rstN = 0;
  logic socEn = 0, clkHold = 0, timStrobe = 0, oeStrobe = 0;
  logic [NCH*8-1:0] memRdata;
  logic [10:0] memAddr;
  logic memAddrValid, outDrive;
  logic [NCH-1:0] chanBit;

  int checks = 0, failures = 0;
  int steps = 0;
  bit expOe = 0;
  bit running = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vecPlayback uut (.clk(clk), .rstN(rstN), .socEn(socEn), .clkHold(clkHold),
    .timStrobe(timStrobe), .oeStrobe(oeStrobe), .memRdata(memRdata),
    .memAddr(memAddr), .memAddrValid(memAddrValid), .chanBit(chanBit),
    .outDrive(outDrive));

  function automatic logic [7:0] memWord(int c, int a);
    if (c == 0 && a == 0) return 8'h67;
    return 8'((a * 37 + c * 91 + (a >> 5) * 13 + 5) & 255);
  endfunction

  always_comb
    for (int c = 0; c < NCH; c++) memRdata[c*8 +: 8] = memWord(c, int'(memAddr));

  function automatic logic expBit(int c, int n);
    int k;
    if (n < 9) return 1'b0;
    k = n - 1;
    return memWord(c, ((k / 8) - 1) % DEPTH)[k % 8];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at step %0d", req, act, exp, steps);
    end
  endtask

  // reference model: count steps and follow the enable latch
  always @(posedge clk) begin
    if (rstN) begin
      if (socEn && !clkHold) steps++;
      if (timStrobe) expOe = 0;
      else if (oeStrobe) expOe = 1;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < NCH; c++) check("R2/R3/R8 chanBit", chanBit[c], expBit(c, steps));
      check("R4 memAddr", memAddr, (steps / 8) % DEPTH);
      check("R7 outDrive", outDrive, expOe);
      check("R5 memAddrValid", memAddrValid, !clkHold);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int frozenAddr;
    logic [NCH-1:0] frozenBits;
    idle(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 chanBit", chanBit, 0);
    check("R1 memAddr", memAddr, 0);
    check("R1 outDrive", outDrive, 0);
    running = 1;

    // R1 / R3: first eight steps give zeros, word 0 starts at step 8
    socEn = 1;
    idle(8);
    check("R1 zeros first word", chanBit, 0);
    idle(1);
    check("R2 first bit of 67h", chanBit[0], 1);
    idle(3);
    check("R2 bit3 of 67h", chanBit[0], 0);
    idle(100);

    // R6: sparse run-clock enable
    for (int i = 0; i < 300; i++) begin
      socEn = (i % 3 == 0);
      @(negedge clk);
    end

    // R5: hold freezes everything
    socEn = 1;
    clkHold = 1;
    frozenAddr = memAddr;
    frozenBits = chanBit;
    idle(40);
    check("R5 addr frozen", memAddr, frozenAddr);
    check("R5 bits frozen", chanBit, frozenBits);
    check("R5 bus released", memAddrValid, 0);

    // R7: latch during hold
    oeStrobe = 1; @(negedge clk); oeStrobe = 0;
    check("R7 set", outDrive, 1);
    idle(5);
    check("R7 keep", outDrive, 1);
    clkHold = 0;
    idle(20);
    timStrobe = 1; @(negedge clk); timStrobe = 0;
    check("R7 clear", outDrive, 0);
    oeStrobe = 1; @(negedge clk); oeStrobe = 0;

    // R4: run past a full wrap of the address counter
    idle(16600);
    check("R4 wrapped", steps > DEPTH * 8, 1);
    idle(50);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule